// File: doc/BRIEF.md
# Two-Path UTOPIA PHY Cell Buffer

This block is the cell-level boundary between a two-path line transceiver and an ATM-layer device. The transceiver produces cells on a low-latency fast path and on an interleaved path. Each path has its own receive buffer of eight 53-byte cells. The ATM layer reads from these buffers over an 8-bit UTOPIA receive port. In the other direction the ATM layer writes cells over an 8-bit UTOPIA transmit port into a matching pair of eight-cell buffers. The transceiver core then drains those buffers one byte at a time.

In multi-PHY (Level 2) mode each path answers to its own configurable 5-bit address. The ATM layer polls an address and gets a cell-available answer on the next cycle. It selects a path by presenting that path's address while its active-low enable is high, and it moves bytes in the cycles where the enable is low. The all-ones address is the null address and never matches. When this port is not addressed, its cell-available and receive data outputs are released through separate output-enable signals so that the lines can be shared on a polled bus. In single-PHY (Level 1) mode the address inputs are ignored and one configured path is always served.

Each direction runs on the clock that the ATM layer supplies for it. The core-side byte ports of that direction are synchronous to the same clock.

Top module: `utl2_phy_buf`

## Requirements
- R1: After reset, in Level 2 mode with the null address presented, u_rx_clav_oe, u_rx_data_oe and u_tx_clav_oe are 0, rxc_ready is 2'b11 and txc_valid is 2'b00.
- R2: A cell is 53 bytes, and the byte offered with start-of-cell is byte 0. Receive cells leave in the order they were written, with their bytes unchanged. u_rx_soc is 1 only while byte 0 is on u_rx_data. Path index 0 is the fast path and path index 1 is the interleaved path, and core-side bus bits [8p+7:8p] belong to path p.
- R3: In Level 2 mode, when u_rx_addr matches a path address in cycle k, in cycle k+1 u_rx_clav_oe is 1 and u_rx_clav is 1 exactly when that path holds a complete cell that has not started leaving. Any other address, including the null address 5'h1F, gives u_rx_clav_oe = 0 in cycle k+1. If both configured addresses are equal, the fast path answers.
- R4: A path is selected by the last cycle in which the enable was high and its address was presented. Selecting a non-matching address deselects the port. Each cycle with the enable low while the port is selected moves one byte. On receive, that byte appears in the next cycle with u_rx_data_oe = 1. u_rx_data_oe is 0 whenever the port was not selected or the enable was high.
- R5: A receive cell is never sent before all 53 of its bytes are stored. While no complete cell is waiting, a transfer cycle outputs data 0 with u_rx_soc = 0 and consumes nothing.
- R6: Transmit bytes accepted while a path is selected are stored in that path. The core side shows txc_valid for a path only while it holds a complete cell. It delivers that cell's bytes in order, with txc_sop on byte 0, one byte per cycle in which txc_ready is 1.
- R7: For an addressed transmit path, u_tx_clav is 1 exactly when the path can take one more whole cell, counting a cell that is partly written. With eight cells stored it is 0, and it returns to 1 once one cell has been drained.
- R8: A transmit start-of-cell that arrives in the middle of a cell discards the partial cell, and the new cell starts in its place. Bytes without start-of-cell that arrive between cells are dropped.
- R9: A receive path holding eight complete cells drops rxc_ready for that path. A cell offered while the path is full is discarded as a whole.
- R10: In Level 1 mode the address inputs are ignored. Both cell-available outputs are driven every cycle, with their output enables at 1, and they report the path chosen by cfg_l1_path. Transfers use that path without any selection step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive-direction clock from the ATM layer |
| rx_rst_n | input | 1 | Active-low asynchronous reset, receive domain |
| tx_clk | input | 1 | Transmit-direction clock from the ATM layer |
| tx_rst_n | input | 1 | Active-low asynchronous reset, transmit domain |
| cfg_l2_mode | input | 1 | 1 selects multi-PHY polling, 0 selects single-PHY |
| cfg_l1_path | input | 1 | Path served in single-PHY mode (0 fast, 1 interleaved) |
| cfg_addr_fast | input | 5 | Port address of the fast path |
| cfg_addr_intl | input | 5 | Port address of the interleaved path |
| rxc_valid | input | 2 | Core receive byte strobe per path |
| rxc_sop | input | 2 | Core receive start-of-cell per path |
| rxc_data | input | 16 | Core receive bytes, 8 bits per path |
| rxc_ready | output | 2 | Receive buffer can take a new cell or is mid-cell |
| u_rx_addr | input | 5 | UTOPIA receive address |
| u_rx_enb_n | input | 1 | UTOPIA receive enable, active low |
| u_rx_data | output | 8 | UTOPIA receive data |
| u_rx_soc | output | 1 | UTOPIA receive start of cell |
| u_rx_data_oe | output | 1 | Drive enable for u_rx_data and u_rx_soc |
| u_rx_clav | output | 1 | UTOPIA receive cell available |
| u_rx_clav_oe | output | 1 | Drive enable for u_rx_clav |
| u_tx_addr | input | 5 | UTOPIA transmit address |
| u_tx_enb_n | input | 1 | UTOPIA transmit enable, active low |
| u_tx_data | input | 8 | UTOPIA transmit data |
| u_tx_soc | input | 1 | UTOPIA transmit start of cell |
| u_tx_clav | output | 1 | UTOPIA transmit cell space available |
| u_tx_clav_oe | output | 1 | Drive enable for u_tx_clav |
| txc_ready | input | 2 | Core takes a transmit byte per path |
| txc_valid | output | 2 | A complete transmit cell is available per path |
| txc_sop | output | 2 | Current transmit byte is byte 0 |
| txc_data | output | 16 | Transmit bytes, 8 bits per path |

## Verification
The hardest states to reach from the ports are the buffer boundaries. One is a path holding exactly eight cells while a ninth is pushed at it. The other is a transmit cell cut off by a fresh start-of-cell partway through. The bench fills the interleaved path with eight distinctly seeded cells in both directions, then offers one more and checks that both the flow-control output and the cell-available answer drop. It then drains everything and compares every byte, which proves the extra cell left no trace. A separate test writes twenty bytes of a cell and then a complete cell with its own start-of-cell, followed by stray bytes. Exactly one cell must come out, and its bytes must be those of the second cell.

// File: rtl/utl2_pkg.sv
package utl2_pkg;

  localparam int CELL_BYTES  = 53;
  localparam int FIFO_CELLS  = 8;
  localparam int NUM_PATHS   = 2;
  localparam int PORT_ADDR_W = 5;
  localparam int BYTE_W      = 8;

  // Flat byte position of byte_i inside slot cell_i of a cell-slotted store.
  function automatic int unsigned flat_index(input int unsigned cell_i,
                                             input int unsigned byte_i,
                                             input int unsigned cell_bytes);
    return cell_i * cell_bytes + byte_i;
  endfunction

endpackage

// File: rtl/utl2_cell_fifo.sv
module utl2_cell_fifo
  import utl2_pkg::*;
#(
  parameter int CELL_LEN    = CELL_BYTES,
  parameter int DEPTH_CELLS = FIFO_CELLS,
  parameter int DATA_W      = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sop,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              room,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sop,
  output logic              rd_valid,
  output logic              rd_new_cell
);

  localparam int IDX_W     = $clog2(CELL_LEN);
  localparam int SLOT_W    = (DEPTH_CELLS > 1) ? $clog2(DEPTH_CELLS) : 1;
  localparam int CNT_W     = $clog2(DEPTH_CELLS + 1);
  localparam int MEM_BYTES = CELL_LEN * DEPTH_CELLS;
  localparam int MADDR_W   = $clog2(MEM_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CELL_LEN - 1);
  localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH_CELLS);

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(DEPTH_CELLS - 1)) ? '0 : s + SLOT_W'(1);
  endfunction

  logic [DATA_W-1:0] mem [MEM_BYTES];
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [IDX_W-1:0]  wr_idx_q, rd_idx_q, wr_idx;
  logic [CNT_W-1:0]  full_cells;

  // Named internal events, used by the assertions below.
  logic wr_mid, sop_ok, cont_ok, do_wr, cell_written, wr_abort;
  logic rd_fire, cell_read;

  always_comb begin
    wr_mid       = (wr_idx_q != '0);
    sop_ok       = wr_en & wr_sop & (full_cells < DEPTH_CNT);
    cont_ok      = wr_en & ~wr_sop & wr_mid;
    do_wr        = sop_ok | cont_ok;
    wr_idx       = sop_ok ? '0 : wr_idx_q;
    cell_written = do_wr & (wr_idx == LAST_IDX);
    wr_abort     = wr_en & wr_sop & wr_mid;
    rd_valid     = (full_cells != '0);
    rd_fire      = rd_en & rd_valid;
    cell_read    = rd_fire & (rd_idx_q == LAST_IDX);
    rd_sop       = (rd_idx_q == '0);
    rd_data      = mem[MADDR_W'(flat_index(32'(rd_slot), 32'(rd_idx_q), 32'(CELL_LEN)))];
    rd_new_cell  = int'(full_cells) > ((rd_idx_q != '0) ? 1 : 0);
    room         = (int'(full_cells) + (wr_mid ? 1 : 0)) < DEPTH_CELLS;
    wr_ready     = wr_mid | (full_cells < DEPTH_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_slot    <= '0;
      rd_slot    <= '0;
      wr_idx_q   <= '0;
      rd_idx_q   <= '0;
      full_cells <= '0;
    end else begin
      if (do_wr) begin
        if (cell_written) begin
          wr_idx_q <= '0;
          wr_slot  <= next_slot(wr_slot);
        end else begin
          wr_idx_q <= wr_idx + IDX_W'(1);
        end
      end
      if (rd_fire) begin
        if (cell_read) begin
          rd_idx_q <= '0;
          rd_slot  <= next_slot(rd_slot);
        end else begin
          rd_idx_q <= rd_idx_q + IDX_W'(1);
        end
      end
      case ({cell_written, cell_read})
        2'b10:   full_cells <= full_cells + CNT_W'(1);
        2'b01:   full_cells <= full_cells - CNT_W'(1);
        default: full_cells <= full_cells;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[MADDR_W'(flat_index(32'(wr_slot), 32'(wr_idx), 32'(CELL_LEN)))] <= wr_data;
  end

  // R9: a finished cell never pushes the count past the slot total
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_written && !cell_read) |-> (full_cells < DEPTH_CNT));
  // R2: the complete-cell count stays within the store
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    full_cells <= DEPTH_CNT);
  // R8: a start-of-cell mid-cell restarts the slot at byte 0
  a_r8_abort_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |=> (wr_idx_q == IDX_W'(1)));

endmodule

// File: rtl/utl2_port_sel.sv
module utl2_port_sel
  import utl2_pkg::*;
#(
  parameter int ADDR_W = PORT_ADDR_W,
  parameter int NPATH  = NUM_PATHS,
  localparam int PATH_W = (NPATH > 1) ? $clog2(NPATH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         l2_mode,
  input  logic [PATH_W-1:0]            l1_path,
  input  logic [NPATH-1:0][ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         enb_n,
  input  logic [NPATH-1:0]             avail,
  output logic                         clav,
  output logic                         clav_oe,
  output logic                         sel_valid,
  output logic [PATH_W-1:0]            sel_path,
  output logic                         xfer
);

  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  function automatic logic addr_match(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] c);
    return (a == c) && (a != NULL_ADDR);
  endfunction

  logic              hit;
  logic [PATH_W-1:0] hit_path;
  logic              sel_q;
  logic [PATH_W-1:0] sel_path_q;

  // Lowest path index wins when addresses collide.
  always_comb begin
    hit      = 1'b0;
    hit_path = '0;
    if (l2_mode) begin
      for (int p = NPATH - 1; p >= 0; p--) begin
        if (addr_match(bus_addr, cfg_addr[p])) begin
          hit      = 1'b1;
          hit_path = PATH_W'(p);
        end
      end
    end else begin
      hit      = 1'b1;
      hit_path = l1_path;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clav       <= 1'b0;
      clav_oe    <= 1'b0;
      sel_q      <= 1'b0;
      sel_path_q <= '0;
    end else begin
      clav    <= hit & avail[hit_path];
      clav_oe <= hit;
      if (enb_n) begin
        sel_q      <= hit;
        sel_path_q <= hit_path;
      end
    end
  end

  always_comb begin
    sel_valid = l2_mode ? sel_q : 1'b1;
    sel_path  = l2_mode ? sel_path_q : l1_path;
    xfer      = ~enb_n & sel_valid;
  end

  // R3: the null address never draws a response
  a_r3_null_addr_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(l2_mode && (bus_addr == NULL_ADDR) && rst_n) |-> !clav_oe);
  // R10: single-PHY mode drives cell-available every cycle
  a_r10_l1_clav_driven: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!l2_mode && rst_n) |-> clav_oe);
  // R4: selection holds while the enable is low
  a_r4_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enb_n && rst_n) |-> (sel_q == $past(sel_q) && sel_path_q == $past(sel_path_q)));

endmodule

// File: rtl/utl2_phy_buf.sv
module utl2_phy_buf
  import utl2_pkg::*;
#(
  parameter int CELL_LEN    = CELL_BYTES,
  parameter int DEPTH_CELLS = FIFO_CELLS,
  parameter int DATA_W      = BYTE_W,
  parameter int ADDR_W      = PORT_ADDR_W,
  localparam int NPATH      = 2,
  localparam int PATH_W     = 1
) (
  input  logic                    rx_clk,
  input  logic                    rx_rst_n,
  input  logic                    tx_clk,
  input  logic                    tx_rst_n,
  input  logic                    cfg_l2_mode,
  input  logic                    cfg_l1_path,
  input  logic [ADDR_W-1:0]       cfg_addr_fast,
  input  logic [ADDR_W-1:0]       cfg_addr_intl,
  input  logic [NPATH-1:0]        rxc_valid,
  input  logic [NPATH-1:0]        rxc_sop,
  input  logic [NPATH*DATA_W-1:0] rxc_data,
  output logic [NPATH-1:0]        rxc_ready,
  input  logic [ADDR_W-1:0]       u_rx_addr,
  input  logic                    u_rx_enb_n,
  output logic [DATA_W-1:0]       u_rx_data,
  output logic                    u_rx_soc,
  output logic                    u_rx_data_oe,
  output logic                    u_rx_clav,
  output logic                    u_rx_clav_oe,
  input  logic [ADDR_W-1:0]       u_tx_addr,
  input  logic                    u_tx_enb_n,
  input  logic [DATA_W-1:0]       u_tx_data,
  input  logic                    u_tx_soc,
  output logic                    u_tx_clav,
  output logic                    u_tx_clav_oe,
  input  logic [NPATH-1:0]        txc_ready,
  output logic [NPATH-1:0]        txc_valid,
  output logic [NPATH-1:0]        txc_sop,
  output logic [NPATH*DATA_W-1:0] txc_data
);

  logic [NPATH-1:0][ADDR_W-1:0] cfg_addr;
  assign cfg_addr = {cfg_addr_intl, cfg_addr_fast};

  // ---------------- receive direction ----------------
  logic [NPATH-1:0]             rx_pop, rx_room, rx_rd_sop, rx_rd_valid, rx_avail;
  logic [NPATH-1:0][DATA_W-1:0] rx_rd_data;
  logic                         rx_sel_valid, rx_xfer, rx_byte_go;
  logic [PATH_W-1:0]            rx_sel_path;

  utl2_port_sel #(.ADDR_W(ADDR_W), .NPATH(NPATH)) u_rx_sel (
    .clk(rx_clk), .rst_n(rx_rst_n), .l2_mode(cfg_l2_mode), .l1_path(cfg_l1_path),
    .cfg_addr(cfg_addr), .bus_addr(u_rx_addr), .enb_n(u_rx_enb_n), .avail(rx_avail),
    .clav(u_rx_clav), .clav_oe(u_rx_clav_oe), .sel_valid(rx_sel_valid),
    .sel_path(rx_sel_path), .xfer(rx_xfer)
  );

  // ---------------- transmit direction ----------------
  logic [NPATH-1:0] tx_wr_en, tx_wr_ready, tx_room, tx_new;
  logic             tx_sel_valid, tx_xfer;
  logic [PATH_W-1:0] tx_sel_path;

  utl2_port_sel #(.ADDR_W(ADDR_W), .NPATH(NPATH)) u_tx_sel (
    .clk(tx_clk), .rst_n(tx_rst_n), .l2_mode(cfg_l2_mode), .l1_path(cfg_l1_path),
    .cfg_addr(cfg_addr), .bus_addr(u_tx_addr), .enb_n(u_tx_enb_n), .avail(tx_room),
    .clav(u_tx_clav), .clav_oe(u_tx_clav_oe), .sel_valid(tx_sel_valid),
    .sel_path(tx_sel_path), .xfer(tx_xfer)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic [DATA_W-1:0] tx_rd_data;
    logic              tx_rd_sop, tx_rd_valid;

    assign rx_pop[p]   = rx_xfer & (rx_sel_path == PATH_W'(p));
    assign tx_wr_en[p] = tx_xfer & (tx_sel_path == PATH_W'(p));

    utl2_cell_fifo #(.CELL_LEN(CELL_LEN), .DEPTH_CELLS(DEPTH_CELLS), .DATA_W(DATA_W)) u_rx_fifo (
      .clk(rx_clk), .rst_n(rx_rst_n),
      .wr_en(rxc_valid[p]), .wr_sop(rxc_sop[p]), .wr_data(rxc_data[p*DATA_W +: DATA_W]),
      .wr_ready(rxc_ready[p]), .room(rx_room[p]),
      .rd_en(rx_pop[p]), .rd_data(rx_rd_data[p]), .rd_sop(rx_rd_sop[p]),
      .rd_valid(rx_rd_valid[p]), .rd_new_cell(rx_avail[p])
    );

    utl2_cell_fifo #(.CELL_LEN(CELL_LEN), .DEPTH_CELLS(DEPTH_CELLS), .DATA_W(DATA_W)) u_tx_fifo (
      .clk(tx_clk), .rst_n(tx_rst_n),
      .wr_en(tx_wr_en[p]), .wr_sop(u_tx_soc), .wr_data(u_tx_data),
      .wr_ready(tx_wr_ready[p]), .room(tx_room[p]),
      .rd_en(txc_ready[p]), .rd_data(tx_rd_data), .rd_sop(tx_rd_sop),
      .rd_valid(tx_rd_valid), .rd_new_cell(tx_new[p])
    );

    assign txc_valid[p]                   = tx_rd_valid;
    assign txc_sop[p]                     = tx_rd_valid & tx_rd_sop;
    assign txc_data[p*DATA_W +: DATA_W]   = tx_rd_data;

    // R7: space for a whole cell implies the writer can start one
    a_r7_room_ready: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
      tx_room[p] |-> tx_wr_ready[p]);
    // R6: a startable cell implies the core side sees it as valid
    a_r6_new_needs_valid: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
      tx_new[p] |-> tx_rd_valid);
    // R9: a receive path refusing new cells has no cell space
    a_r9_rx_ready_room: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
      !rxc_ready[p] |-> !rx_room[p]);
  end

  assign rx_byte_go = rx_xfer & rx_rd_valid[rx_sel_path];

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      u_rx_data    <= '0;
      u_rx_soc     <= 1'b0;
      u_rx_data_oe <= 1'b0;
    end else begin
      u_rx_data_oe <= rx_xfer;
      u_rx_data    <= rx_byte_go ? rx_rd_data[rx_sel_path] : '0;
      u_rx_soc     <= rx_byte_go & rx_rd_sop[rx_sel_path];
    end
  end

  // R4: data is driven only after a sampled low enable
  a_r4_rx_oe_after_enable: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    u_rx_data_oe |-> $past(!u_rx_enb_n));
  // R2: start-of-cell is never shown on released lines
  a_r2_soc_driven: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    u_rx_soc |-> u_rx_data_oe);
  // R4: transfers need a selection (single-PHY mode always has one)
  a_r4_sel_for_xfer: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (tx_xfer || rx_xfer) |-> (tx_sel_valid || rx_sel_valid));

endmodule

// File: tb/utl2_phy_buf_bench.sv
module utl2_phy_buf_bench;

  localparam int CL = 53;
  localparam logic [4:0] A_FAST = 5'd3;
  localparam logic [4:0] A_INTL = 5'd12;
  localparam logic [4:0] A_NULL = 5'h1F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_l2_mode = 1'b1, cfg_l1_path = 1'b0;
  logic [4:0]  cfg_addr_fast = A_FAST, cfg_addr_intl = A_INTL;
  logic [1:0]  rxc_valid = '0, rxc_sop = '0, rxc_ready;
  logic [15:0] rxc_data = '0;
  logic [4:0]  u_rx_addr = A_NULL, u_tx_addr = A_NULL;
  logic        u_rx_enb_n = 1'b1, u_tx_enb_n = 1'b1, u_tx_soc = 1'b0;
  logic [7:0]  u_rx_data, u_tx_data = '0;
  logic        u_rx_soc, u_rx_data_oe, u_rx_clav, u_rx_clav_oe, u_tx_clav, u_tx_clav_oe;
  logic [1:0]  txc_ready = '0, txc_valid, txc_sop;
  logic [15:0] txc_data;

  utl2_phy_buf u_utl2_phy_buf (
    .rx_clk(clk), .rx_rst_n(rst_n), .tx_clk(clk), .tx_rst_n(rst_n),
    .cfg_l2_mode(cfg_l2_mode), .cfg_l1_path(cfg_l1_path),
    .cfg_addr_fast(cfg_addr_fast), .cfg_addr_intl(cfg_addr_intl),
    .rxc_valid(rxc_valid), .rxc_sop(rxc_sop), .rxc_data(rxc_data), .rxc_ready(rxc_ready),
    .u_rx_addr(u_rx_addr), .u_rx_enb_n(u_rx_enb_n), .u_rx_data(u_rx_data),
    .u_rx_soc(u_rx_soc), .u_rx_data_oe(u_rx_data_oe), .u_rx_clav(u_rx_clav),
    .u_rx_clav_oe(u_rx_clav_oe), .u_tx_addr(u_tx_addr), .u_tx_enb_n(u_tx_enb_n),
    .u_tx_data(u_tx_data), .u_tx_soc(u_tx_soc), .u_tx_clav(u_tx_clav),
    .u_tx_clav_oe(u_tx_clav_oe), .txc_ready(txc_ready), .txc_valid(txc_valid),
    .txc_sop(txc_sop), .txc_data(txc_data)
  );

  int n_checks = 0, n_fails = 0, cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 17 + i * 3 + 1);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  // Core-side receive writer: bytes first..last of a cell on path p.
  task automatic rx_push(input int p, input int seed, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      @(negedge clk);
      rxc_valid = '0; rxc_sop = '0;
      rxc_valid[p] = 1'b1;
      rxc_sop[p] = (i == 0);
      rxc_data[p*8 +: 8] = pat(seed, i);
    end
    @(negedge clk);
    rxc_valid = '0; rxc_sop = '0;
  endtask

  task automatic rx_poll(input logic [4:0] a, input int oe, input int cl, input string tag);
    @(negedge clk);
    u_rx_addr = a; u_rx_enb_n = 1'b1;
    @(posedge clk); #1;
    chk({tag, " rx clav_oe"}, int'(u_rx_clav_oe), oe);
    if (oe != 0) chk({tag, " rx clav"}, int'(u_rx_clav), cl);
  endtask

  task automatic rx_read_cell(input int seed, input string tag);
    @(negedge clk);
    u_rx_enb_n = 1'b0;
    for (int i = 0; i < CL; i++) begin
      @(posedge clk); #1;
      chk({tag, " rx data"}, int'(u_rx_data), int'(pat(seed, i)));
      chk({tag, " rx soc"}, int'(u_rx_soc), (i == 0) ? 1 : 0);
      chk({tag, " rx oe"}, int'(u_rx_data_oe), 1);
    end
    @(negedge clk);
    u_rx_enb_n = 1'b1;
  endtask

  task automatic tx_poll(input logic [4:0] a, input int oe, input int cl, input string tag);
    @(negedge clk);
    u_tx_addr = a; u_tx_enb_n = 1'b1;
    @(posedge clk); #1;
    chk({tag, " tx clav_oe"}, int'(u_tx_clav_oe), oe);
    if (oe != 0) chk({tag, " tx clav"}, int'(u_tx_clav), cl);
  endtask

  task automatic tx_write(input logic [4:0] a, input int seed, input int nbytes, input bit with_soc);
    @(negedge clk);
    u_tx_addr = a; u_tx_enb_n = 1'b1;
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      u_tx_enb_n = 1'b0;
      u_tx_data = pat(seed, i);
      u_tx_soc = with_soc && (i == 0);
    end
    @(negedge clk);
    u_tx_enb_n = 1'b1; u_tx_soc = 1'b0;
  endtask

  task automatic txc_drain(input int p, input int seed, input string tag);
    for (int i = 0; i < CL; i++) begin
      @(negedge clk);
      chk({tag, " txc valid"}, int'(txc_valid[p]), 1);
      chk({tag, " txc data"}, int'(txc_data[p*8 +: 8]), int'(pat(seed, i)));
      chk({tag, " txc sop"}, int'(txc_sop[p]), (i == 0) ? 1 : 0);
      txc_ready[p] = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    txc_ready = '0;
  endtask

  task automatic t_reset;
    chk("R1 rx clav_oe", int'(u_rx_clav_oe), 0);
    chk("R1 rx data_oe", int'(u_rx_data_oe), 0);
    chk("R1 tx clav_oe", int'(u_tx_clav_oe), 0);
    chk("R1 rxc_ready", int'(rxc_ready), 3);
    chk("R1 txc_valid", int'(txc_valid), 0);
  endtask

  task automatic t_rx_poll_empty;
    rx_poll(A_FAST, 1, 0, "R3 empty fast");
    rx_poll(A_NULL, 0, 0, "R3 null");
    rx_poll(5'd9, 0, 0, "R3 foreign");
  endtask

  task automatic t_rx_single;
    rx_push(0, 1, 0, CL - 1);
    rx_poll(A_INTL, 1, 0, "R3 other path");
    rx_poll(A_FAST, 1, 1, "R3 fast full");
    rx_read_cell(1, "R2 fast cell");
    rx_poll(A_FAST, 1, 0, "R3 fast drained");
  endtask

  task automatic t_rx_partial;
    rx_push(0, 2, 0, 29);
    rx_poll(A_FAST, 1, 0, "R5 partial clav");
    @(negedge clk); u_rx_enb_n = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1;
      chk("R5 partial soc", int'(u_rx_soc), 0);
      chk("R5 partial data", int'(u_rx_data), 0);
    end
    @(negedge clk); u_rx_enb_n = 1'b1;
    rx_push(0, 2, 30, CL - 1);
    rx_poll(A_FAST, 1, 1, "R5 completed clav");
    rx_read_cell(2, "R5 completed cell");
  endtask

  task automatic t_rx_two_paths;
    rx_push(0, 3, 0, CL - 1);
    rx_push(1, 4, 0, CL - 1);
    rx_push(0, 5, 0, CL - 1);
    rx_poll(A_INTL, 1, 1, "R3 intl poll");
    rx_read_cell(4, "R2 intl first");
    rx_poll(A_FAST, 1, 1, "R3 fast poll");
    rx_read_cell(3, "R2 fast order a");
    rx_read_cell(5, "R2 fast order b");
    cfg_addr_intl = A_FAST;
    rx_push(1, 6, 0, CL - 1);
    rx_poll(A_FAST, 1, 0, "R3 tie fast wins");
    cfg_addr_intl = A_INTL;
    rx_poll(A_INTL, 1, 1, "R3 tie restore");
    rx_read_cell(6, "R3 tie cell");
  endtask

  task automatic t_rx_deselect;
    rx_push(0, 7, 0, CL - 1);
    rx_poll(5'd9, 0, 0, "R4 deselect");
    @(negedge clk); u_rx_enb_n = 1'b0;
    @(posedge clk); #1;
    chk("R4 deselected oe", int'(u_rx_data_oe), 0);
    @(negedge clk); u_rx_enb_n = 1'b1;
    @(posedge clk); #1;
    chk("R4 enable high oe", int'(u_rx_data_oe), 0);
    rx_poll(A_FAST, 1, 1, "R4 cell kept");
    rx_read_cell(7, "R4 reselected cell");
  endtask

  task automatic t_rx_full;
    for (int c = 0; c < 8; c++) rx_push(1, 20 + c, 0, CL - 1);
    chk("R9 rxc_ready full", int'(rxc_ready[1]), 0);
    rx_push(1, 99, 0, CL - 1);
    rx_poll(A_INTL, 1, 1, "R9 full clav");
    for (int c = 0; c < 8; c++) rx_read_cell(20 + c, "R9 drain");
    rx_poll(A_INTL, 1, 0, "R9 extra cell dropped");
    chk("R9 rxc_ready empty", int'(rxc_ready[1]), 1);
  endtask

  task automatic t_tx_basic;
    tx_poll(A_FAST, 1, 1, "R7 empty room");
    tx_poll(A_NULL, 0, 0, "R3 tx null");
    tx_write(A_FAST, 40, CL, 1'b1);
    @(negedge clk);
    chk("R6 intl idle", int'(txc_valid[1]), 0);
    txc_drain(0, 40, "R6 fast cell");
    @(negedge clk);
    chk("R6 fast empty", int'(txc_valid[0]), 0);
  endtask

  task automatic t_tx_abort;
    tx_write(A_FAST, 41, 20, 1'b1);
    @(negedge clk);
    chk("R8 partial invisible", int'(txc_valid[0]), 0);
    tx_write(A_FAST, 42, CL, 1'b1);
    tx_write(A_FAST, 43, 10, 1'b0);
    txc_drain(0, 42, "R8 surviving cell");
    @(negedge clk);
    chk("R8 nothing else", int'(txc_valid[0]), 0);
  endtask

  task automatic t_tx_full;
    for (int c = 0; c < 8; c++) tx_write(A_INTL, 50 + c, CL, 1'b1);
    tx_poll(A_INTL, 1, 0, "R7 full");
    tx_poll(A_FAST, 1, 1, "R7 other free");
    txc_drain(1, 50, "R7 first out");
    tx_poll(A_INTL, 1, 1, "R7 room again");
    for (int c = 1; c < 8; c++) txc_drain(1, 50 + c, "R7 drain");
  endtask

  task automatic t_level1;
    rx_push(0, 60, 0, CL - 1);
    @(negedge clk);
    cfg_l2_mode = 1'b0; cfg_l1_path = 1'b1;
    rx_poll(A_FAST, 1, 0, "R10 addr ignored");
    rx_poll(A_NULL, 1, 0, "R10 null driven");
    rx_push(1, 61, 0, CL - 1);
    rx_poll(A_FAST, 1, 1, "R10 intl reported");
    rx_read_cell(61, "R10 l1 read");
    tx_poll(A_NULL, 1, 1, "R10 tx driven");
    tx_write(A_NULL, 62, CL, 1'b1);
    @(negedge clk);
    chk("R10 fast untouched", int'(txc_valid[0]), 0);
    txc_drain(1, 62, "R10 l1 write");
    @(negedge clk);
    cfg_l2_mode = 1'b1; cfg_l1_path = 1'b0;
    rx_poll(A_FAST, 1, 1, "R10 back to l2");
    rx_read_cell(60, "R10 fast kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_rx_poll_empty();
    t_rx_single();
    t_rx_partial();
    t_rx_two_paths();
    t_rx_deselect();
    t_rx_full();
    t_tx_basic();
    t_tx_abort();
    t_tx_full();
    t_level1();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule